// File: doc/BRIEF.md
# Accelerator Control and Interrupt Register Bank

This block is the small register file that software uses to steer a signal-processing accelerator and to learn what happened inside it. It sits on a plain 32-bit register bus that carries an address, a write strobe with write data, and a read strobe. Read data returns on a registered output. Three words are mapped:

- a control word with a soft-reset bit and a run-enable bit;
- an event word whose sticky flags are set by hardware pulses and cleared by software writing ones;
- an interrupt-mask word.

The engines and the bus master that raise the event pulses sit outside this block. Each pulse arrives on its own bit of `evt_pulse`. The block drives one level-sensitive interrupt request, together with the resolved run-enable and soft-reset levels that go to the engines.

The soft-reset bit takes priority over everything it touches. While the bit is set, the run-enable output is forced low and every event flag is held at zero. Pulses that arrive during that time are dropped. The stored enable bit and the mask word keep their values, so releasing soft reset restores the previous enable setting.

Top module: `accel_csr`

## Requirements
- R1: After rst_n is released, reads of offsets 0x0, 0x4 and 0x8 return 0, and irq, core_enable and soft_reset are 0.
- R2: The control word is at offset 0x0. Bit 31 is soft reset and bit 0 is run enable; all other bits read as 0. The soft_reset output equals bit 31. The core_enable output equals bit 0 only while bit 31 is 0, and is 0 while bit 31 is 1.
- R3: The event word is at offset 0x4. A 1 on evt_pulse[k] sets flag k for k in {0,1,3,4,5,6,7}; the flag stays set after the pulse ends. Bit 2 always reads 0 and ignores both pulses and writes.
- R4: Writing offset 0x4 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R5: If evt_pulse[k] and a clear of flag k occur in the same cycle, flag k ends up set.
- R6: While soft reset is set, including the cycle in which the write that sets it lands, all event flags are 0 and event pulses are ignored. The stored enable bit and the mask word keep their values.
- R7: The mask word is at offset 0x8. All 32 bits are readable and writable, and bits 7:0 line up with the event flag positions.
- R8: irq is 1 whenever some event flag and its mask bit are both 1. It stays at that level until the flag or the mask bit is cleared.
- R9: Reads of any other offset return 0. Writes to any other offset change none of the three words.
- R10: bus_rdata updates at the clock edge where bus_re is sampled high, taking the register value from before that edge. It holds its value while bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| evt_pulse | input | EVT_W | One-cycle event pulses, one per flag position |
| core_enable | output | 1 | Run enable, gated by soft reset |
| soft_reset | output | 1 | Soft-reset level for the engines |
| irq | output | 1 | Level interrupt request |

## Verification
A write or an event pulse shows up on core_enable, soft_reset and irq right after the next rising edge. A read value appears on bus_rdata after the same single edge.

The bench drives every stimulus half a cycle ahead of a rising edge and samples on the following falling edge, which is exactly one register stage later. A result that took an extra cycle or none would fail there. For the same-cycle collision and for the cycle in which soft reset lands, the bench puts both stimuli into one driven cycle before it samples.

// File: rtl/accel_csr.sv
module accel_csr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic              core_enable,
  output logic              soft_reset,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_IEN  = ADDR_W'(8);
  localparam int SRST_BIT = DATA_W - 1;
  localparam logic [EVT_W-1:0] EVT_LIVE = ~(EVT_W'(1) << 2);

  logic              srst_q, en_q;
  logic [EVT_W-1:0]  stat_q;
  logic [DATA_W-1:0] ien_q, rdata_q, rd_mux;

  wire sel_ctrl = bus_addr == OFF_CTRL;
  wire sel_stat = bus_addr == OFF_STAT;
  wire sel_ien  = bus_addr == OFF_IEN;
  wire wr_ctrl  = bus_we && sel_ctrl;
  wire srst_nxt = wr_ctrl ? bus_wdata[SRST_BIT] : srst_q;
  wire [EVT_W-1:0] clr_mask = (bus_we && sel_stat) ? bus_wdata[EVT_W-1:0] : '0;
  wire [EVT_W-1:0] evt_live = evt_pulse & EVT_LIVE;

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)      rd_mux = {srst_q, {(DATA_W-2){1'b0}}, en_q};
    else if (sel_stat) rd_mux = DATA_W'(stat_q);
    else if (sel_ien)  rd_mux = ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b0;
      en_q    <= 1'b0;
      stat_q  <= '0;
      ien_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) begin
        srst_q <= bus_wdata[SRST_BIT];
        en_q   <= bus_wdata[0];
      end
      if (bus_we && sel_ien) ien_q <= bus_wdata;
      stat_q <= srst_nxt ? '0 : ((stat_q & ~clr_mask) | evt_live);
      if (bus_re) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata   = rdata_q;
  assign soft_reset  = srst_q;
  assign core_enable = en_q && !srst_q;
  assign irq         = |(stat_q & ien_q[EVT_W-1:0]);
endmodule

// File: rtl/accel_csr_chk.sv
module accel_csr_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int EVT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [EVT_W-1:0]  evt_pulse,
  input logic              core_enable,
  input logic              soft_reset,
  input logic              irq,
  input logic [EVT_W-1:0]  stat_q,
  input logic [DATA_W-1:0] ien_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8);

  p_en_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> !core_enable);

  p_bit2_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[2]);

  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_STAT && bus_wdata[1] && !evt_pulse[1]) |=> !stat_q[1]);

  p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse[0] && !soft_reset && !(bus_we && bus_addr == A_CTRL)) |=> stat_q[0]);

  p_srst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> (stat_q == '0));

  p_ien_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_IEN) |=> $stable(ien_q));

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(stat_q) && $stable(ien_q)) |-> $stable(irq));
endmodule

bind accel_csr accel_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .evt_pulse(evt_pulse), .core_enable(core_enable),
  .soft_reset(soft_reset), .irq(irq), .stat_q(stat_q), .ien_q(ien_q)
);

// File: tb/tb_accel_csr.sv
`timescale 1ns/1ps
module tb_accel_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        core_enable, soft_reset, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  accel_csr dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .core_enable(core_enable),
    .soft_reset(soft_reset), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [7:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h04, v); check("R1 stat", v, 32'h0);
    rd(8'h08, v); check("R1 ien", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 core_enable", {31'b0, core_enable}, 32'h0);
    check("R1 soft_reset", {31'b0, soft_reset}, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    check("R2 soft_reset set", {31'b0, soft_reset}, 32'h1);
    check("R2 enable gated", {31'b0, core_enable}, 32'h0);
    rd(8'h00, v); check("R2 ctrl readback", v, 32'h8000_0001);
    wr(8'h00, 32'h0000_0001);
    check("R2 enable live", {31'b0, core_enable}, 32'h1);
    check("R2 soft_reset clear", {31'b0, soft_reset}, 32'h0);
    rd(8'h00, v); check("R2 ctrl readback 2", v, 32'h0000_0001);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(8'h08, 32'hA5A5_5A5A);
    rd(8'h08, v); check("R7 mask readback", v, 32'hA5A5_5A5A);
    wr(8'h08, 32'h0);
    rd(8'h08, v); check("R7 mask cleared", v, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] v;
    pulse(8'hFF);
    check("R8 masked no irq", {31'b0, irq}, 32'h0);
    rd(8'h04, v); check("R3 flags set, bit2 zero", v, 32'h0000_00FB);
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, v); check("R3 bit2 write ignored", v, 32'h0000_00FB);
    wr(8'h08, 32'h0000_0008);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    check("R8 irq level holds", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0000_0008);
    check("R8 irq drops on clear", {31'b0, irq}, 32'h0);
    rd(8'h04, v); check("R4 one flag cleared", v, 32'h0000_00F3);
    wr(8'h04, 32'h0000_00F3);
    rd(8'h04, v); check("R4 all cleared", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    pulse(8'h03);
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'h3; bus_we = 1'b1; evt_pulse = 8'h01;
    @(negedge clk);
    bus_we = 1'b0; evt_pulse = '0;
    rd(8'h04, v); check("R5 event beats clear", v, 32'h1);
    wr(8'h04, 32'h1);
  endtask

  task automatic t_srst;
    logic [31:0] v;
    wr(8'h08, 32'h0000_00FF);
    pulse(8'h10);
    check("R8 irq from flag 4", {31'b0, irq}, 32'h1);
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'h8000_0001; bus_we = 1'b1; evt_pulse = 8'h01;
    @(negedge clk);
    bus_we = 1'b0; evt_pulse = '0;
    check("R6 irq off in soft reset", {31'b0, irq}, 32'h0);
    rd(8'h04, v); check("R6 flags zero", v, 32'h0);
    pulse(8'hFF);
    rd(8'h04, v); check("R6 pulses ignored", v, 32'h0);
    rd(8'h08, v); check("R6 mask kept", v, 32'h0000_00FF);
    wr(8'h00, 32'h0000_0001);
    check("R6 enable restored", {31'b0, core_enable}, 32'h1);
    pulse(8'h40);
    rd(8'h04, v); check("R6 flags live after release", v, 32'h40);
    wr(8'h04, 32'hFF);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R9 read 0x20", v, 32'h0);
    rd(8'h0C, v); check("R9 read 0x0C", v, 32'h0);
    rd(8'h00, v); check("R9 ctrl untouched", v, 32'h1);
    rd(8'h04, v); check("R9 stat untouched", v, 32'h0);
    rd(8'h08, v); check("R9 mask untouched", v, 32'h0000_00FF);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    rd(8'h08, v);
    wr(8'h08, 32'h1234_5678);
    repeat (2) @(negedge clk);
    check("R10 rdata holds", bus_rdata, 32'h0000_00FF);
    rd(8'h08, v); check("R10 new read", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_mask();
    t_events();
    t_collide();
    t_srst();
    t_unmapped();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule